// File: doc/BRIEF.md
# Pointer-Selected Banked Register Window

This block holds a processor's general-purpose registers inside a 512-byte window of internal RAM, from byte address 0x000180 to 0x00037F. The window is cut into 32 banks of 16 bytes. A 5-bit bank pointer picks one bank as the active register set. The active bank starts at byte address 0x000180 + pointer × 0x10. Software can write the pointer and read it back.

A register port serves the CPU. It names a register by a kind (byte, word or long word) and an index, and it reads or writes the active bank. The three kinds are overlapping views of the same bytes. A second port is byte-wide and memory-mapped. It reaches every byte of the window by absolute address. Both ports share one byte array, so a value written through one port can be read at once through the other.

Register and memory reads are combinational. All writes take effect at the rising clock edge. Reset is synchronous and active high. It clears the pointer and every stored byte.

Top module: `gpr_bank_window`

## Requirements
- R1: Reset clears the bank pointer to 0 and every byte of the window to 0.
- R2: A pointer write is visible on `rp_rd` from the next cycle. A register access in the same cycle as the pointer write still uses the old bank.
- R3: With `reg_kind` = 2'b01 (word), index i addresses bank bytes 2i (bits 7:0) and 2i+1 (bits 15:8). Read bits 31:16 are 0. Bank byte b of bank p is memory address 0x180 + 16p + b.
- R4: With `reg_kind` = 2'b10 (long), index bits 1:0 select j. RLj covers bank bytes 4j..4j+3, little-endian, so RW(2j) is its low half. Index bit 2 is ignored.
- R5: With `reg_kind` = 2'b00 (byte), index i addresses bank byte 8+i on bits 7:0. Read bits 31:8 are 0.
- R6: A register write changes only the bytes its kind covers. All other bytes of the window keep their values.
- R7: A memory-port address inside 0x180..0x37F sets `mem_hit`. A read returns that byte, and a write stores `mem_wr_data` there.
- R8: A memory-port address outside 0x180..0x37F clears `mem_hit` and reads 0. A write there changes no byte of the window.
- R9: When both ports write in one cycle, both writes take effect. If they write the same byte, the register port's value is the one stored.
- R10: `reg_kind` = 2'b11 reads 0, and a write with it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_wr_en | input | 1 | Load the bank pointer |
| rp_wr_data | input | 5 | New bank pointer value |
| rp_rd | output | 5 | Current bank pointer |
| reg_kind | input | 2 | 00 byte, 01 word, 10 long, 11 none |
| reg_idx | input | 3 | Register index inside the active bank |
| reg_wr_en | input | 1 | Write the selected register |
| reg_wr_data | input | 32 | Register write data, right-aligned |
| reg_rd_data | output | 32 | Register read data, zero-extended |
| mem_addr | input | 24 | Memory-port byte address |
| mem_wr_en | input | 1 | Memory-port byte write |
| mem_wr_data | input | 8 | Memory-port write byte |
| mem_rd_data | output | 8 | Memory-port read byte (0 when not hit) |
| mem_hit | output | 1 | Address lies inside the window |

## Verification
A register write and a memory-port write can land in the same cycle. They may hit the same byte or neighbouring bytes of one register. The bench provokes this in two ways: directed cycles aim a memory byte write at a byte that a word write covers and at a byte just beside it, and random traffic keeps the memory address close to the active bank. The reference model applies the memory write first and the register write second. Every later read, through either port, must match that order. A pointer change in the same cycle as a register write is also provoked, to judge that the write lands in the old bank.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int NUM_BANKS   = 32;
    localparam int BANK_BYTES  = 16;
    localparam int LANES       = 4;
    localparam int RP_W        = $clog2(NUM_BANKS);
    localparam int OFF_W       = $clog2(BANK_BYTES);
    localparam int STORE_BYTES = NUM_BANKS * BANK_BYTES;
    localparam int STORE_AW    = RP_W + OFF_W;
    localparam int ADDR_W      = 24;
    localparam logic [ADDR_W-1:0] WIN_BASE = 24'h000180;

    typedef enum logic [1:0] {
        GPR_BYTE = 2'b00,
        GPR_WORD = 2'b01,
        GPR_LONG = 2'b10,
        GPR_NONE = 2'b11
    } gpr_kind_e;

    typedef struct packed {
        logic [LANES-1:0] en;
        logic [OFF_W-1:0] off;
    } gpr_slot_t;

    // Lanes used and first bank byte of a register view.
    function automatic gpr_slot_t gpr_slot(input logic [1:0] kind, input logic [2:0] idx);
        gpr_slot_t s;
        s.en  = '0;
        s.off = '0;
        case (gpr_kind_e'(kind))
            GPR_BYTE: begin s.en = 4'b0001; s.off = {1'b1, idx};          end
            GPR_WORD: begin s.en = 4'b0011; s.off = {idx, 1'b0};          end
            GPR_LONG: begin s.en = 4'b1111; s.off = {idx[1:0], 2'b00};    end
            default:  begin s.en = 4'b0000; s.off = '0;                   end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpr_bank_ptr.sv
module gpr_bank_ptr #(
    parameter int RP_W = gpr_pkg::RP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [RP_W-1:0] wr_data,
    output logic [RP_W-1:0] rp
);
    always_ff @(posedge clk) begin
        if (rst)
            rp <= '0;
        else if (wr_en)
            rp <= wr_data;
    end
endmodule

// File: rtl/gpr_reg_decode.sv
module gpr_reg_decode
    import gpr_pkg::*;
#(
    parameter int RP_W  = gpr_pkg::RP_W,
    parameter int OFF_W = gpr_pkg::OFF_W,
    parameter int LANES = gpr_pkg::LANES,
    localparam int AW   = RP_W + OFF_W
) (
    input  logic [RP_W-1:0]           rp,
    input  logic [1:0]                kind,
    input  logic [2:0]                idx,
    output logic [LANES-1:0]          lane_en,
    output logic [LANES-1:0][AW-1:0]  lane_addr
);
    gpr_slot_t slot;

    always_comb slot = gpr_slot(kind, idx);
    assign lane_en = slot.en;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [OFF_W-1:0] STEP = OFF_W'(k);
        // A view never crosses the bank edge, so the bank field is fixed.
        assign lane_addr[k] = {rp, slot.off + STEP};
    end
endmodule

// File: rtl/gpr_byte_store.sv
module gpr_byte_store #(
    parameter int DEPTH = gpr_pkg::STORE_BYTES,
    parameter int LANES = gpr_pkg::LANES,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES-1:0]          lane_we,
    input  logic [LANES-1:0][AW-1:0]  lane_addr,
    input  logic [LANES-1:0][7:0]     lane_wd,
    output logic [LANES-1:0][7:0]     lane_rd,
    input  logic                      m_we,
    input  logic [AW-1:0]             m_addr,
    input  logic [7:0]                m_wd,
    output logic [7:0]                m_rd
);
    logic [7:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                bytes_q[i] <= '0;
        end else begin
            if (m_we)
                bytes_q[m_addr] <= m_wd;
            // Register lanes come later so they override on a shared byte.
            for (int k = 0; k < LANES; k++)
                if (lane_we[k])
                    bytes_q[lane_addr[k]] <= lane_wd[k];
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign lane_rd[k] = bytes_q[lane_addr[k]];
    end
    assign m_rd = bytes_q[m_addr];
endmodule

// File: rtl/gpr_bank_window.sv
module gpr_bank_window
    import gpr_pkg::*;
#(
    parameter int NBANK  = gpr_pkg::NUM_BANKS,
    parameter int BBYTES = gpr_pkg::BANK_BYTES,
    parameter int AWIDTH = gpr_pkg::ADDR_W,
    parameter logic [AWIDTH-1:0] BASE = gpr_pkg::WIN_BASE,
    localparam int RPW   = $clog2(NBANK),
    localparam int OFW   = $clog2(BBYTES),
    localparam int DEPTH = NBANK * BBYTES,
    localparam int SAW   = RPW + OFW,
    localparam logic [AWIDTH-1:0] TOP = BASE + AWIDTH'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rp_wr_en,
    input  logic [RPW-1:0]    rp_wr_data,
    output logic [RPW-1:0]    rp_rd,
    input  logic [1:0]        reg_kind,
    input  logic [2:0]        reg_idx,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    input  logic [AWIDTH-1:0] mem_addr,
    input  logic              mem_wr_en,
    input  logic [7:0]        mem_wr_data,
    output logic [7:0]        mem_rd_data,
    output logic              mem_hit
);
    logic [RPW-1:0]              rp_q;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][SAW-1:0]   lane_addr;
    logic [LANES-1:0][7:0]       lane_rd;
    logic [LANES-1:0][7:0]       lane_wd;
    logic [LANES-1:0]            lane_we;
    logic [SAW-1:0]              m_off;
    logic [AWIDTH-1:0]           m_diff;
    logic [7:0]                  m_rd;

    gpr_bank_ptr #(.RP_W(RPW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rp_wr_en),
        .wr_data (rp_wr_data),
        .rp      (rp_q)
    );
    assign rp_rd = rp_q;

    gpr_reg_decode #(.RP_W(RPW), .OFF_W(OFW), .LANES(LANES)) u_dec (
        .rp        (rp_q),
        .kind      (reg_kind),
        .idx       (reg_idx),
        .lane_en   (lane_en),
        .lane_addr (lane_addr)
    );

    assign mem_hit = (mem_addr >= BASE) && (mem_addr <= TOP);
    assign m_diff  = mem_addr - BASE;
    assign m_off   = m_diff[SAW-1:0];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_wd[k]           = reg_wr_data[8*k +: 8];
        assign lane_we[k]           = reg_wr_en & lane_en[k];
        assign reg_rd_data[8*k +: 8] = lane_en[k] ? lane_rd[k] : 8'h00;
    end

    gpr_byte_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .lane_we   (lane_we),
        .lane_addr (lane_addr),
        .lane_wd   (lane_wd),
        .lane_rd   (lane_rd),
        .m_we      (mem_wr_en & mem_hit),
        .m_addr    (m_off),
        .m_wd      (mem_wr_data),
        .m_rd      (m_rd)
    );

    assign mem_rd_data = mem_hit ? m_rd : 8'h00;
endmodule

// File: rtl/gpr_bank_window_chk.sv
module gpr_bank_window_chk (
    input logic        clk,
    input logic        rst,
    input logic        rp_wr_en,
    input logic [4:0]  rp_wr_data,
    input logic [4:0]  rp_rd,
    input logic [1:0]  reg_kind,
    input logic [2:0]  reg_idx,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic [23:0] mem_addr,
    input logic [7:0]  mem_rd_data,
    input logic        mem_hit
);
    assert_rp_cleared_R1: assert property (@(posedge clk)
        rst |=> rp_rd == 5'd0);

    assert_rp_load_R2: assert property (@(posedge clk) disable iff (rst)
        rp_wr_en |=> rp_rd == $past(rp_wr_data));

    assert_rp_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rp_wr_en |=> $stable(rp_rd));

    assert_word_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        reg_kind == 2'b01 |-> reg_rd_data[31:16] == 16'h0);

    assert_byte_writeback_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_kind == 2'b00 && !rp_wr_en)
        ##1 (reg_kind == 2'b00 && reg_idx == $past(reg_idx))
        |-> reg_rd_data == {24'h0, $past(reg_wr_data[7:0])});

    assert_below_window_R8: assert property (@(posedge clk) disable iff (rst)
        mem_addr < 24'h000180 |-> !mem_hit);

    assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !mem_hit |-> mem_rd_data == 8'h00);

    assert_none_kind_zero_R10: assert property (@(posedge clk) disable iff (rst)
        reg_kind == 2'b11 |-> reg_rd_data == 32'h0);
endmodule

bind gpr_bank_window gpr_bank_window_chk u_chk (.*);

// File: tb/tb_gpr_bank_window.sv
`timescale 1ns/1ps
module tb_gpr_bank_window;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rp_wr_en = 1'b0;
    logic [4:0]  rp_wr_data = '0;
    logic [4:0]  rp_rd;
    logic [1:0]  reg_kind = 2'b01;
    logic [2:0]  reg_idx = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [23:0] mem_addr = 24'h000180;
    logic        mem_wr_en = 1'b0;
    logic [7:0]  mem_wr_data = '0;
    logic [7:0]  mem_rd_data;
    logic        mem_hit;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    byte unsigned model [512];
    int mrp = 0;
    string tag_ovr = "";

    always #2.5 clk = ~clk;

    gpr_bank_window dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_reg(input int k, input int i);
        int b;
        b = mrp * 16;
        case (k)
            0: return model[b + 8 + i];
            1: return {model[b + 2*i + 1], model[b + 2*i]};
            2: return {model[b + 4*(i%4) + 3], model[b + 4*(i%4) + 2],
                       model[b + 4*(i%4) + 1], model[b + 4*(i%4)]};
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rp_wr_en = 0; reg_wr_en = 0; mem_wr_en = 0;
        @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < 512; j++) model[j] = 0;
        mrp = 0;
    endtask

    // One cycle: drive, check the combinational view, then advance the model.
    task automatic cyc(input bit rwe, input int rd, input int k, input int i,
                       input bit we, input logic [31:0] wd,
                       input int ma, input bit mwe, input int md);
        string rt, mt;
        int b;
        bit hit;
        @(negedge clk);
        rp_wr_en = rwe; rp_wr_data = 5'(rd);
        reg_kind = 2'(k); reg_idx = 3'(i); reg_wr_en = we; reg_wr_data = wd;
        mem_addr = 24'(ma); mem_wr_en = mwe; mem_wr_data = 8'(md);
        #1;
        hit = (ma >= 'h180) && (ma <= 'h37F);
        rt = (k == 0) ? "R5" : (k == 1) ? "R3" : (k == 2) ? "R4" : "R10";
        mt = hit ? "R7" : "R8";
        if (tag_ovr != "") begin rt = tag_ovr; mt = tag_ovr; end
        chk(rt, reg_rd_data, 32'(exp_reg(k, i)));
        chk(mt, {31'b0, mem_hit}, {31'b0, hit});
        chk(mt, {24'b0, mem_rd_data}, hit ? {24'b0, model[ma - 'h180]} : 32'h0);
        chk((tag_ovr != "") ? tag_ovr : "R2", {27'b0, rp_rd}, 32'(mrp));
        if (mwe && hit) model[ma - 'h180] = 8'(md);
        b = mrp * 16;
        if (we) begin
            case (k)
                0: model[b + 8 + i] = wd[7:0];
                1: begin model[b + 2*i] = wd[7:0]; model[b + 2*i + 1] = wd[15:8]; end
                2: for (int q = 0; q < 4; q++) model[b + 4*(i%4) + q] = wd[8*q +: 8];
                default: ;
            endcase
        end
        if (rwe) mrp = rd;
    endtask

    task automatic idle_read(input int k, input int i, input int ma);
        cyc(0, 0, k, i, 0, 0, ma, 0, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 512; j++) model[j] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        tag_ovr = "R1";
        for (int i = 0; i < 8; i++) idle_read(1, i, 'h180 + 2*i);
        idle_read(2, 3, 'h37F);
        tag_ovr = "";

        // R3: word writes in bank 0, checked through memory
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, i, 1, 32'hA500 + i*17, 'h180, 0, 0);
        for (int i = 0; i < 16; i++) idle_read(1, i % 8, 'h180 + i);

        // R2: pointer change in same cycle as a word write; write uses old bank
        tag_ovr = "R2";
        cyc(1, 5, 1, 0, 1, 32'h0000BEEF, 'h180, 0, 0);
        idle_read(1, 0, 'h180);
        idle_read(1, 0, 'h1D0);
        tag_ovr = "";

        // R4: long write with index bit 2 set, seen as two words
        cyc(0, 0, 2, 5, 1, 32'h11223344, 'h1D4, 0, 0);
        idle_read(1, 2, 'h1D4);
        idle_read(1, 3, 'h1D7);
        idle_read(2, 1, 'h1D5);

        // R5: byte R3 is bank byte 11
        cyc(0, 0, 0, 3, 1, 32'hFFFFFF5A, 'h1DB, 0, 0);
        idle_read(1, 5, 'h1DB);
        idle_read(0, 3, 'h1DA);

        // R6: byte write inside a long leaves the other three bytes
        tag_ovr = "R6";
        cyc(0, 0, 2, 3, 1, 32'hCAFEF00D, 'h1DC, 0, 0);
        cyc(0, 0, 0, 4, 1, 32'h00000077, 'h1DC, 0, 0);
        idle_read(2, 3, 'h1DC);
        idle_read(2, 2, 'h1DB);
        tag_ovr = "";

        // R7: memory writes reach the register view
        cyc(0, 0, 1, 6, 0, 0, 'h1DC, 1, 'h42);
        cyc(0, 0, 1, 6, 0, 0, 'h1DD, 1, 'h24);
        idle_read(1, 6, 'h1DC);

        // R8: outside the window
        cyc(0, 0, 1, 0, 0, 0, 'h17F, 1, 'h99);
        cyc(0, 0, 1, 0, 0, 0, 'h380, 1, 'h99);
        idle_read(1, 0, 'h180);
        idle_read(1, 7, 'h37F);

        // R9: collision on a shared byte, and a neighbouring byte
        tag_ovr = "R9";
        cyc(0, 0, 1, 1, 1, 32'h0000A1B2, 'h1D2, 1, 'hEE);
        idle_read(1, 1, 'h1D2);
        cyc(0, 0, 1, 1, 1, 32'h0000C3D4, 'h1D4, 1, 'h5C);
        idle_read(1, 1, 'h1D4);
        idle_read(1, 2, 'h1D3);
        tag_ovr = "";

        // R10: kind 11 reads zero and writes nothing
        cyc(0, 0, 3, 2, 1, 32'hDEADBEEF, 'h1D4, 0, 0);
        for (int i = 0; i < 8; i++) idle_read(1, i, 'h1D0 + 2*i);

        // R1: reset again after dirty state
        do_reset();
        tag_ovr = "R1";
        idle_read(1, 0, 'h180);
        idle_read(2, 1, 'h1D4);
        tag_ovr = "";

        // Mixed traffic near the active bank
        for (int n = 0; n < 4000; n++) begin
            int ma;
            ma = 'h170 + (mrp * 16) + int'($urandom_range(0, 40));
            if ($urandom_range(0, 9) == 0) ma = int'($urandom_range('h100, 'h3FF));
            cyc(($urandom_range(0, 15) == 0), int'($urandom_range(0, 31)),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                ($urandom_range(0, 2) == 0), $urandom,
                ma, ($urandom_range(0, 2) == 0), int'($urandom_range(0, 255)));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule